// File: doc/BRIEF.md
# LED Fault Capture and Readout

This block watches the per-channel fault indications of a 16-channel LED sink driver and produces the 16-bit status word that the shared serial shift register loads in parallel for readout. In normal mode it only gates the channel drivers. In special mode, holding the output-enable input low starts a capture run. After two consecutive low samples the block switches the shift register's data source from the serial input to the status word. It then asserts a parallel-load strobe on every later low sample. When output enable returns high, the source reverts to serial and the captured word shifts out, most significant bit first.

Each status bit reads 1 for a healthy channel and 0 for a fault. A channel that is not driven also reads 0, because nothing can be measured on it. Open-load is judged from a current-below-threshold indication. A short is held with hysteresis between a trigger comparator and a lower return comparator.

Overtemperature turns channels off at once. A channel restarts by itself once it cools, if its latch bit still asks for it. Its status bit, however, stays at 0 until the block goes back to normal mode. Faults seen after the settle window of a run are sticky in the same way. A capture that ends before `SETTLE_CYC` low samples have passed is flagged as invalid.

Top module: `led_fault_capture`

## Requirements
- R1: `drive_en[i]` is 1 exactly when `oe_n` is 0, `chan_cmd[i]` is 1, `chan_hot[i]` is 0 and `glob_hot` is 0, in either mode; with `oe_n` high every channel is off.
- R2: In special mode, `sel_par` (1 = shift register takes the parallel status word, 0 = serial input) rises after the second consecutive low sample of `oe_n`. It falls after the first high sample, and it is never 1 in normal mode.
- R3: `par_load` is 1 in each cycle whose closing clock edge takes the third or a later consecutive low `oe_n` sample in special mode.
- R4: Status bit i of `status_word` belongs to channel i: 1 means healthy and 0 means fault; a channel with `drive_en[i]` = 0 reads 0.
- R5: A driven channel with `cur_low[i]` = 1 (current below the open-load threshold) reads 0.
- R6: The short flag of a channel sets on a clock edge that samples `v_trip[i]` = 1. It clears only on an edge that samples `v_rel[i]` = 1 with `v_trip[i]` = 0, and otherwise it holds. A set short flag makes the bit read 0.
- R7: `chan_hot[i]` turns only channel i off and clears only its bit. After cooling the channel drives again if commanded, but in special mode its bit stays 0 until normal mode is entered.
- R8: `glob_hot` turns every channel off and clears every bit, and in special mode all bits stay 0 after cooling until normal mode is entered.
- R9: In special mode, an open-load or short fault on a driven channel seen once the run has `SETTLE_CYC` low samples keeps that bit at 0 after the fault goes away. A fault that disappears before that point leaves no trace.
- R10: `cap_invalid` is loaded when `oe_n` is sampled high while `sel_par` is 1. It becomes 1 if fewer than `SETTLE_CYC` low samples were taken in the run and 0 otherwise, and it holds at all other times.
- R11: While `special` is 0 no fault is retained; the word reflects only the present indications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| special | input | 1 | 1 while the control block is in special mode |
| oe_n | input | 1 | Output enable, active low; a low run triggers capture in special mode |
| chan_cmd | input | 16 | Output-latch bits; 1 asks channel i to sink current |
| cur_low | input | 16 | Channel current below the open-load threshold |
| v_trip | input | 16 | Channel voltage above the short trigger level |
| v_rel | input | 16 | Channel voltage below the short return level |
| chan_hot | input | 16 | Per-channel overtemperature |
| glob_hot | input | 1 | Global overtemperature |
| drive_en | output | 16 | Channel driver enables |
| status_word | output | 16 | Parallel status word, 1 = healthy |
| sel_par | output | 1 | Shift register source select, 1 = parallel word |
| par_load | output | 1 | Parallel-load strobe for the shift register |
| cap_invalid | output | 1 | Last capture ended before the settle window |

## Verification
The hardest situation to reach is telling a fault that appears inside the settle window from one that appears after it. Both look the same at the word for a cycle and differ only once the indication is withdrawn. The stimulus restarts a low run from normal mode so that nothing is left over from before. It raises `cur_low` for a known number of low samples, either below or above `SETTLE_CYC`, drops it, and then reads the word. The thermal restart case is reached in the same way: the bench cools a channel while the run is still low and watches `drive_en` come back while the status bit stays at 0.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;

  // Saturating run length of consecutive low enable samples (0..3).
  function automatic logic [1:0] f_run_next(input logic [1:0] cnt, input logic low_in_mode);
    if (!low_in_mode) return 2'd0;
    if (cnt == 2'd3) return 2'd3;
    return cnt + 2'd1;
  endfunction

  // Healthy flag of one channel: driven, no live fault, nothing retained.
  function automatic logic f_chan_ok(input logic driven, input logic bad_now, input logic retained);
    return driven & ~bad_now & ~retained;
  endfunction

  // Next short flag with hysteresis: trip sets, release clears, else hold.
  function automatic logic f_short_next(input logic cur, input logic trip, input logic rel);
    if (trip) return 1'b1;
    if (rel) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/lfc_oe_run.sv
module lfc_oe_run
  import led_fault_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic special,
  input  logic oe_n,
  output logic sel_par,
  output logic par_load,
  output logic settle_done,
  output logic cap_invalid
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_MAX = SW'(SETTLE_CYC);

  logic [1:0]    run_q;
  logic [SW-1:0] settle_q;
  logic          low_in_mode;

  assign low_in_mode = special & ~oe_n;
  assign sel_par     = special & (run_q >= 2'd2);
  assign par_load    = sel_par & ~oe_n;
  assign settle_done = (settle_q == SETTLE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 2'd0;
      settle_q    <= '0;
      cap_invalid <= 1'b0;
    end else begin
      run_q <= f_run_next(run_q, low_in_mode);
      if (!low_in_mode)
        settle_q <= '0;
      else if (!settle_done)
        settle_q <= settle_q + 1'b1;
      if (sel_par && oe_n)
        cap_invalid <= ~settle_done;
    end
  end
endmodule

// File: rtl/lfc_short_hyst.sv
module lfc_short_hyst
  import led_fault_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] v_trip,
  input  logic [NCH-1:0] v_rel,
  output logic [NCH-1:0] short_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) short_q[g] <= 1'b0;
      else        short_q[g] <= f_short_next(short_q[g], v_trip[g], v_rel[g]);
    end
  end
endmodule

// File: rtl/lfc_chan_status.sv
module lfc_chan_status
  import led_fault_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           special,
  input  logic           oe_n,
  input  logic           settle_done,
  input  logic [NCH-1:0] chan_cmd,
  input  logic [NCH-1:0] cur_low,
  input  logic [NCH-1:0] short_q,
  input  logic [NCH-1:0] chan_hot,
  input  logic           glob_hot,
  output logic [NCH-1:0] drive_en,
  output logic [NCH-1:0] status_word
);
  logic [NCH-1:0] retained_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hot, bad_now, grab;
    assign hot         = chan_hot[g] | glob_hot;
    assign drive_en[g] = ~oe_n & chan_cmd[g] & ~hot;
    assign bad_now     = cur_low[g] | short_q[g];
    assign grab        = hot | (settle_done & drive_en[g] & bad_now);
    assign status_word[g] = f_chan_ok(drive_en[g], bad_now, retained_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        retained_q[g] <= 1'b0;
      else if (!special) retained_q[g] <= 1'b0;
      else               retained_q[g] <= retained_q[g] | grab;
    end
  end
endmodule

// File: rtl/led_fault_capture.sv
module led_fault_capture #(
  parameter int NCH        = 16,
  parameter int SETTLE_CYC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           special,
  input  logic           oe_n,
  input  logic [NCH-1:0] chan_cmd,
  input  logic [NCH-1:0] cur_low,
  input  logic [NCH-1:0] v_trip,
  input  logic [NCH-1:0] v_rel,
  input  logic [NCH-1:0] chan_hot,
  input  logic           glob_hot,
  output logic [NCH-1:0] drive_en,
  output logic [NCH-1:0] status_word,
  output logic           sel_par,
  output logic           par_load,
  output logic           cap_invalid
);
  logic           settle_done;
  logic [NCH-1:0] short_q;

  lfc_oe_run #(.SETTLE_CYC(SETTLE_CYC)) u_run (
    .clk(clk), .rst_n(rst_n), .special(special), .oe_n(oe_n),
    .sel_par(sel_par), .par_load(par_load),
    .settle_done(settle_done), .cap_invalid(cap_invalid)
  );

  lfc_short_hyst #(.NCH(NCH)) u_short (
    .clk(clk), .rst_n(rst_n), .v_trip(v_trip), .v_rel(v_rel), .short_q(short_q)
  );

  lfc_chan_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .special(special), .oe_n(oe_n),
    .settle_done(settle_done), .chan_cmd(chan_cmd), .cur_low(cur_low),
    .short_q(short_q), .chan_hot(chan_hot), .glob_hot(glob_hot),
    .drive_en(drive_en), .status_word(status_word)
  );
endmodule

// File: rtl/led_fault_capture_chk.sv
module led_fault_capture_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           special,
  input logic           oe_n,
  input logic [NCH-1:0] v_rel,
  input logic [NCH-1:0] drive_en,
  input logic [NCH-1:0] status_word,
  input logic [NCH-1:0] short_q,
  input logic           glob_hot,
  input logic           sel_par,
  input logic           par_load,
  input logic           cap_invalid
);
  a_r1_blank_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> drive_en == '0);

  a_r2_sel_after_two_lows: assert property (@(posedge clk) disable iff (!rst_n)
    sel_par |-> (!$past(oe_n) && !$past(oe_n, 2)));

  a_r3_load_on_third_low: assert property (@(posedge clk) disable iff (!rst_n)
    par_load |-> (!oe_n && !$past(oe_n) && !$past(oe_n, 2)));

  a_r4_off_reads_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~drive_en) == '0);

  a_r6_short_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(short_q) & ~$past(v_rel)) & ~short_q) == '0);

  a_r8_global_hot_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (special && $past(special) && $past(glob_hot)) |-> status_word == '0);

  a_r10_invalid_at_run_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_invalid) |-> ($past(sel_par) && $past(oe_n)));
endmodule

bind led_fault_capture led_fault_capture_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .special(special), .oe_n(oe_n), .v_rel(v_rel),
  .drive_en(drive_en), .status_word(status_word), .short_q(short_q),
  .glob_hot(glob_hot), .sel_par(sel_par), .par_load(par_load),
  .cap_invalid(cap_invalid)
);

// File: tb/led_fault_capture_tb_top.sv
module led_fault_capture_tb_top;
  localparam int NCH = 16;
  localparam int SET = 8;
  localparam int NV  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic special = 1'b0, oe_n = 1'b1, glob_hot = 1'b0;
  logic [NCH-1:0] chan_cmd = '0, cur_low = '0, v_trip = '0, v_rel = '0, chan_hot = '0;
  logic [NCH-1:0] drive_en, status_word;
  logic sel_par, par_load, cap_invalid;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  led_fault_capture #(.NCH(NCH), .SETTLE_CYC(SET)) dut_i (
    .clk(clk), .rst_n(rst_n), .special(special), .oe_n(oe_n),
    .chan_cmd(chan_cmd), .cur_low(cur_low), .v_trip(v_trip), .v_rel(v_rel),
    .chan_hot(chan_hot), .glob_hot(glob_hot), .drive_en(drive_en),
    .status_word(status_word), .sel_par(sel_par), .par_load(par_load),
    .cap_invalid(cap_invalid)
  );

  localparam logic [15:0] T_CMD  [NV] = '{16'hFFFF, 16'hA5A5, 16'hFFFF, 16'hFFFF, 16'h0FF0, 16'hFFFF};
  localparam logic [15:0] T_LOW  [NV] = '{16'h0000, 16'h0000, 16'h00F0, 16'h0000, 16'h0110, 16'h0000};
  localparam logic [15:0] T_TRIP [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h8001, 16'h0F00, 16'h0000};
  localparam logic [15:0] T_HOT  [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0003, 16'h0000};
  localparam logic        T_GLOB [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  function automatic logic [15:0] exp_drive(logic [15:0] c, logic [15:0] h, logic g);
    return g ? 16'h0000 : (c & ~h);
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(2);
    chk("R10 reset cap_invalid", {15'd0, cap_invalid}, 16'd0);
    chk("R2 reset sel_par", {15'd0, sel_par}, 16'd0);
    chk("R4 reset word", status_word, 16'h0000);
    rst_n = 1'b1;
    step(1);

    // Vector table in normal mode: live indications only (R5, R6, R4, R1, R11).
    oe_n = 1'b0;
    for (int k = 0; k < NV; k++) begin
      cur_low = '0; v_trip = '0; v_rel = '1; chan_hot = '0; glob_hot = 1'b0;
      step(1);
      chan_cmd = T_CMD[k]; cur_low = T_LOW[k]; v_trip = T_TRIP[k]; v_rel = '0;
      chan_hot = T_HOT[k]; glob_hot = T_GLOB[k];
      step(1);
      chk("R1 table drive", drive_en, exp_drive(T_CMD[k], T_HOT[k], T_GLOB[k]));
      chk("R5 table word", status_word,
          exp_drive(T_CMD[k], T_HOT[k], T_GLOB[k]) & ~T_LOW[k] & ~T_TRIP[k]);
    end
    cur_low = '0; v_trip = '0; v_rel = '1; chan_hot = '0; glob_hot = 1'b0;
    chan_cmd = 16'hFFFF;
    step(4);
    chk("R2 no select in normal mode", {15'd0, sel_par}, 16'd0);
    chk("R11 normal mode word live", status_word, 16'hFFFF);

    // Short hysteresis on channel 2 (R6).
    v_rel = '0; v_trip = 16'h0004; step(1);
    v_trip = '0; step(2);
    chk("R6 short held without release", status_word, 16'hFFFB);
    v_rel = 16'h0004; step(1);
    chk("R6 short cleared by release", status_word, 16'hFFFF);

    // OE high blanks (R1).
    oe_n = 1'b1; step(1);
    chk("R1 blank drive", drive_en, 16'h0000);
    chk("R4 off reads zero", status_word, 16'h0000);

    // Special-mode capture run timing (R2, R3, R10).
    special = 1'b1; step(1);
    oe_n = 1'b0; step(1);
    chk("R2 one low sample", {15'd0, sel_par}, 16'd0);
    step(1);
    chk("R2 two low samples", {15'd0, sel_par}, 16'd1);
    chk("R3 load strobe", {15'd0, par_load}, 16'd1);
    step(SET);
    oe_n = 1'b1; step(1);
    chk("R2 select drops", {15'd0, sel_par}, 16'd0);
    chk("R3 no load when high", {15'd0, par_load}, 16'd0);
    chk("R10 long run valid", {15'd0, cap_invalid}, 16'd0);
    oe_n = 1'b0; step(3);
    oe_n = 1'b1; step(1);
    chk("R10 short run invalid", {15'd0, cap_invalid}, 16'd1);
    step(2);
    chk("R10 flag holds", {15'd0, cap_invalid}, 16'd1);

    // Sticky open-load after settle (R9).
    oe_n = 1'b0; step(SET + 1);
    cur_low = 16'h0020; step(1);
    chk("R5 open load live", status_word, 16'hFFDF);
    cur_low = '0; step(1);
    chk("R9 open load retained", status_word, 16'hFFDF);

    // Fault inside settle window is not retained (R9).
    special = 1'b0; oe_n = 1'b1; step(1);
    special = 1'b1; step(1);
    oe_n = 1'b0; cur_low = 16'h0040; step(3);
    cur_low = '0; step(SET);
    chk("R9 early fault dropped", status_word, 16'hFFFF);

    // Channel overtemperature and restart (R7).
    chan_hot = 16'h0008; step(1);
    chk("R7 hot channel off", drive_en, 16'hFFF7);
    chk("R7 hot bit cleared", status_word, 16'hFFF7);
    chan_hot = '0; step(1);
    chk("R7 restart drive", drive_en, 16'hFFFF);
    chk("R7 bit stays cleared", status_word, 16'hFFF7);
    special = 1'b0; step(1);
    chk("R11 normal mode restores", status_word, 16'hFFFF);

    // Global overtemperature (R8).
    special = 1'b1; step(1);
    glob_hot = 1'b1; step(1);
    chk("R8 all off", drive_en, 16'h0000);
    glob_hot = 1'b0; step(1);
    chk("R8 drive restarts", drive_en, 16'hFFFF);
    chk("R8 bits stay cleared", status_word, 16'h0000);
    special = 1'b0; step(1);
    chk("R11 cleared after normal", status_word, 16'hFFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule